// File: doc/BRIEF.md
# Region to Page-Entry Mapper

This block turns a memory region, given as a start address and a byte length, into a set of identity translation entries held in a small slot table. A map command splits the region greedily. At each step it takes the largest supported page size that both divides the current address and does not exceed the remaining length. It places that page in the lowest-numbered free slot, advances the address and shrinks the remaining length by the page size. It repeats until nothing is left or an error stops it. An unmap command clears, in a single step, every valid slot whose page lies wholly inside a given range.

The slot table spans two chained translation buffers, so its capacity is twice the per-buffer entry count. A read port lets the translation side inspect any slot. The bench uses the same port to observe what the sequencer wrote. Eight page sizes are supported, coded 0 to 7: 4 KiB, 16 KiB, 64 KiB, 2 MiB, 32 MiB, 512 MiB, 1 GiB and 16 GiB.

Top module: `region_mapper`

## Requirements
- R1: After reset, busy, done and err are 0, and every slot reads mode 2'b00 (invalid) on the read port.
- R2: A map command places pages one per cycle. Each page uses the largest size code (0=4K, 1=16K, 2=64K, 3=2M, 4=32M, 5=512M, 6=1G, 7=16G) whose size is at most the remaining length and divides the current address.
- R3: Each new page goes to the lowest-indexed slot whose mode reads invalid.
- R4: A written slot reads mode 2'b10 (valid), equal virtual and physical bases set to the page address, its size code, and permission field 6'b111111.
- R5: busy is high from the cycle after an accepted start until the command ends. done is a one-cycle pulse with busy low. count then gives the number of slots written by a map, or cleared by an unmap.
- R6: When a page is due but no slot is free, the map stops with err = 1 (no space). Slots already written by that command stay valid.
- R7: When a page is due but no size fits the address alignment, the map stops with err = 2 (unaligned), keeping earlier slots. If no slot is free either, err = 1 wins.
- R8: Unmap (cmd = 1) invalidates exactly those valid slots whose page start is at or above the range start and whose page end is at or below start plus length. Partly overlapping slots stay valid.
- R9: A start pulse while busy is ignored. The running command completes with its own result.
- R10: A map with length 0 ends with count 0 and err = 0, writing nothing.
- R11: The table holds 2 x TLB_ENTRIES slots (16 by default), and all of them are usable before no-space is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, accepted when idle |
| cmd | input | 1 | 0 = map, 1 = unmap |
| addr | input | ADDR_W | Region start address |
| len | input | ADDR_W+1 | Region length in bytes |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 none, 1 no space, 2 unaligned |
| count | output | CNT_W | Slots written or cleared by the last command |
| q_idx | input | IDX_W | Slot index for the read port |
| q_mode | output | 2 | Mode of the addressed slot |
| q_vbase | output | ADDR_W | Virtual base of the addressed slot |
| q_pbase | output | ADDR_W | Physical base of the addressed slot |
| q_code | output | 4 | Page size code of the addressed slot |
| q_perm | output | 6 | Permission bits of the addressed slot |

## Verification
In a map step, the free-slot search and the page-size choice are settled in the same cycle, and both can fail together. The bench fills every slot and then issues a map at an address that is not 4 KiB aligned, so both conditions hold at once. It expects the no-space code, not the unaligned code. A start pulse arriving in the middle of a multi-page map is the second collision. It is judged by the first command's page count, error and slot contents, none of which may change.

// File: rtl/rmap_pkg.sv
package rmap_pkg;

  localparam int NUM_PSIZE = 8;
  localparam logic [1:0] MODE_INVALID = 2'b00;
  localparam logic [1:0] MODE_VALID   = 2'b10;
  localparam logic [5:0] PERM_ALL     = 6'h3F;

  localparam logic [1:0] ERR_NONE      = 2'd0;
  localparam logic [1:0] ERR_NOSPACE   = 2'd1;
  localparam logic [1:0] ERR_UNALIGNED = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_MAP, ST_UNMAP} rmap_state_e;

  // log2 of the page size for each size code
  function automatic int unsigned pg_shift(input logic [2:0] code);
    case (code)
      3'd0: return 12;
      3'd1: return 14;
      3'd2: return 16;
      3'd3: return 21;
      3'd4: return 25;
      3'd5: return 29;
      3'd6: return 30;
      default: return 34;
    endcase
  endfunction

  function automatic logic [63:0] pg_bytes(input logic [2:0] code);
    return 64'd1 << pg_shift(code);
  endfunction

endpackage

// File: rtl/rmap_page_pick.sv
module rmap_page_pick
  import rmap_pkg::*;
#(
  parameter int ADDR_W = 40,
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  rem_len,
  output logic              fit,
  output logic [2:0]        code,
  output logic [LEN_W-1:0]  size
);

  logic [63:0] a64, r64;
  logic [NUM_PSIZE-1:0] cand;

  assign a64 = 64'(cur_addr);
  assign r64 = 64'(rem_len);

  for (genvar k = 0; k < NUM_PSIZE; k++) begin : g_cand
    assign cand[k] = (r64 >= pg_bytes(3'(k))) &&
                     ((a64 & (pg_bytes(3'(k)) - 64'd1)) == 64'd0);
  end

  // later (larger) candidates overwrite earlier ones
  always_comb begin
    fit  = 1'b0;
    code = 3'd0;
    for (int k = 0; k < NUM_PSIZE; k++) begin
      if (cand[k]) begin
        fit  = 1'b1;
        code = 3'(k);
      end
    end
    size = LEN_W'(pg_bytes(code));
  end

  a_r2_page_fits: assert property (@(posedge clk) disable iff (!rst_n)
    fit |-> ((size <= rem_len) && ((64'(cur_addr) & (64'(size) - 64'd1)) == 64'd0)));

  a_r2_larger_unfit: assert property (@(posedge clk) disable iff (!rst_n)
    (fit && code != 3'd7) |->
      ((r64 < pg_bytes(code + 3'd1)) || ((a64 & (pg_bytes(code + 3'd1) - 64'd1)) != 64'd0)));

endmodule

// File: rtl/rmap_free_find.sv
module rmap_free_find #(
  parameter int SLOTS = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] used,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // descending walk so the lowest free index is left standing
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!used[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  a_r3_free_is_free: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> !used[idx]);

  a_r6_none_free: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (&used));

endmodule

// File: rtl/rmap_slot_table.sv
module rmap_slot_table
  import rmap_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int ADDR_W = 40,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [2:0]        wr_code,
  input  logic              rm_en,
  input  logic [LEN_W-1:0]  rm_lo,
  input  logic [LEN_W-1:0]  rm_hi,
  output logic [SLOTS-1:0]  used,
  output logic [SLOTS-1:0]  rm_hits,
  input  logic [IDX_W-1:0]  q_idx,
  output logic [1:0]        q_mode,
  output logic [ADDR_W-1:0] q_vbase,
  output logic [ADDR_W-1:0] q_pbase,
  output logic [3:0]        q_code,
  output logic [5:0]        q_perm
);

  logic [1:0]        mode_q  [SLOTS];
  logic [ADDR_W-1:0] vbase_q [SLOTS];
  logic [ADDR_W-1:0] pbase_q [SLOTS];
  logic [3:0]        code_q  [SLOTS];
  logic [5:0]        perm_q  [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [LEN_W-1:0] pg_lo, pg_hi;
    assign pg_lo      = {1'b0, vbase_q[i]};
    assign pg_hi      = pg_lo + LEN_W'(pg_bytes(code_q[i][2:0]));
    assign used[i]    = (mode_q[i] != MODE_INVALID);
    // codes of 8 and above are left alone
    assign rm_hits[i] = (mode_q[i] == MODE_VALID) && !code_q[i][3] &&
                        (pg_lo >= rm_lo) && (pg_hi <= rm_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        mode_q[i]  <= MODE_INVALID;
        vbase_q[i] <= '0;
        pbase_q[i] <= '0;
        code_q[i]  <= '0;
        perm_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (wr_en && wr_idx == IDX_W'(i)) begin
          mode_q[i]  <= MODE_VALID;
          vbase_q[i] <= wr_base;
          pbase_q[i] <= wr_base;
          code_q[i]  <= {1'b0, wr_code};
          perm_q[i]  <= PERM_ALL;
        end else if (rm_en && rm_hits[i]) begin
          mode_q[i] <= MODE_INVALID;
        end
      end
    end
  end

  assign q_mode  = mode_q[q_idx];
  assign q_vbase = vbase_q[q_idx];
  assign q_pbase = pbase_q[q_idx];
  assign q_code  = code_q[q_idx];
  assign q_perm  = perm_q[q_idx];

  a_r3_write_target_free: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (mode_q[wr_idx] == MODE_INVALID));

  a_r8_write_remove_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rm_en));

endmodule

// File: rtl/region_mapper.sv
module region_mapper
  import rmap_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int TLB_ENTRIES = 8,
  localparam int SLOTS = 2 * TLB_ENTRIES,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err,
  output logic [CNT_W-1:0]  count,
  input  logic [IDX_W-1:0]  q_idx,
  output logic [1:0]        q_mode,
  output logic [ADDR_W-1:0] q_vbase,
  output logic [ADDR_W-1:0] q_pbase,
  output logic [3:0]        q_code,
  output logic [5:0]        q_perm
);

  rmap_state_e       state_q;
  logic              op_q;
  logic [ADDR_W-1:0] cur_q;
  logic [LEN_W-1:0]  rem_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        err_q;
  logic              done_q;

  // named internal events
  logic              pg_fit;
  logic [2:0]        pg_code;
  logic [LEN_W-1:0]  pg_size;
  logic [SLOTS-1:0]  slot_used, slot_hits;
  logic              free_found;
  logic [IDX_W-1:0]  free_idx;
  logic              map_step, map_end, wr_en, rm_en;
  logic [LEN_W-1:0]  rm_hi;

  rmap_page_pick #(.ADDR_W(ADDR_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .cur_addr(cur_q), .rem_len(rem_q),
    .fit(pg_fit), .code(pg_code), .size(pg_size)
  );

  rmap_free_find #(.SLOTS(SLOTS)) u_free (
    .clk(clk), .rst_n(rst_n), .used(slot_used), .found(free_found), .idx(free_idx)
  );

  assign map_step = (state_q == ST_MAP) && (rem_q != '0);
  assign wr_en    = map_step && free_found && pg_fit;
  assign map_end  = (state_q == ST_MAP) && !wr_en;
  assign rm_en    = (state_q == ST_UNMAP);
  assign rm_hi    = {1'b0, cur_q} + rem_q;

  rmap_slot_table #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(free_idx), .wr_base(cur_q), .wr_code(pg_code),
    .rm_en(rm_en), .rm_lo({1'b0, cur_q}), .rm_hi(rm_hi),
    .used(slot_used), .rm_hits(slot_hits),
    .q_idx(q_idx), .q_mode(q_mode), .q_vbase(q_vbase), .q_pbase(q_pbase),
    .q_code(q_code), .q_perm(q_perm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= 1'b0;
      cur_q   <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      err_q   <= ERR_NONE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          op_q    <= cmd;
          cur_q   <= addr;
          rem_q   <= len;
          cnt_q   <= '0;
          err_q   <= ERR_NONE;
          state_q <= cmd ? ST_UNMAP : ST_MAP;
        end
        ST_MAP: begin
          if (wr_en) begin
            cur_q <= cur_q + ADDR_W'(pg_size);
            rem_q <= rem_q - pg_size;
            cnt_q <= cnt_q + 1'b1;
          end else begin
            // slot shortage outranks misalignment
            if (map_step && !free_found)  err_q <= ERR_NOSPACE;
            else if (map_step && !pg_fit) err_q <= ERR_UNALIGNED;
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_UNMAP: begin
          cnt_q   <= CNT_W'($countones(slot_hits));
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state_q != ST_IDLE);
  assign done  = done_q;
  assign err   = err_q;
  assign count = cnt_q;

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r5_finish_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (map_end && rem_q == '0) |=> (done && err == ERR_NONE));

  a_r9_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(op_q)));

  a_r6_err_ends_map: assert property (@(posedge clk) disable iff (!rst_n)
    (map_step && !free_found) |=> (done && err == ERR_NOSPACE));

endmodule

// File: tb/region_mapper_tb_top.sv
`timescale 1ns/1ps
module region_mapper_tb_top;

  localparam int AW = 40;
  localparam int LW = AW + 1;
  localparam int NS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] len = '0;
  logic busy, done;
  logic [1:0] err;
  logic [4:0] count;
  logic [3:0] q_idx = '0;
  logic [1:0] q_mode;
  logic [AW-1:0] q_vbase, q_pbase;
  logic [3:0] q_code;
  logic [5:0] q_perm;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  region_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr), .len(len),
    .busy(busy), .done(done), .err(err), .count(count), .q_idx(q_idx),
    .q_mode(q_mode), .q_vbase(q_vbase), .q_pbase(q_pbase), .q_code(q_code),
    .q_perm(q_perm)
  );

  typedef struct packed {
    logic [AW-1:0] a;
    logic [LW-1:0] l;
    logic [4:0]    n;
    logic [1:0]    e;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{a: 40'h0,          l: 41'h1000,        n: 5'd1, e: 2'd0},
    '{a: 40'h1000,       l: 41'h7000,        n: 5'd4, e: 2'd0},
    '{a: 40'h4_0000_0000, l: 41'h4_4000_0000, n: 5'd2, e: 2'd0},
    '{a: 40'h20_0000,    l: 41'h22_0000,     n: 5'd3, e: 2'd0},
    '{a: 40'h800,        l: 41'h1000,        n: 5'd0, e: 2'd2},
    '{a: 40'h1000,       l: 41'h1800,        n: 5'd1, e: 2'd2},
    '{a: 40'h12345000,   l: 41'h0,           n: 5'd0, e: 2'd0}
  };

  // bench-side page ladder, as byte counts
  function automatic logic [63:0] size_of(input int c);
    logic [63:0] t [8] = '{64'h1000, 64'h4000, 64'h10000, 64'h200000,
                           64'h2000000, 64'h20000000, 64'h40000000, 64'h400000000};
    return t[c];
  endfunction

  // largest code whose size fits the length and divides the address, -1 if none
  function automatic int best_code(input logic [63:0] a, input logic [63:0] r);
    for (int c = 7; c >= 0; c--)
      if (r >= size_of(c) && (a % size_of(c)) == 0) return c;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic c, input logic [AW-1:0] a, input logic [LW-1:0] l);
    @(negedge clk);
    start = 1'b1; cmd = c; addr = a; len = l;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic peek(input int i);
    q_idx = 4'(i);
    #0.1;
  endtask

  task automatic expect_slot(input string req, input int i, input logic [63:0] base, input int code);
    peek(i);
    chk(req, 64'(q_mode), 64'h2);
    chk(req, 64'(q_vbase), base);
    chk(req, 64'(q_pbase), base);
    chk(req, 64'(q_code), 64'(code));
    chk(req, 64'(q_perm), 64'h3F);
  endtask

  task automatic expect_free(input string req, input int i);
    peek(i);
    chk(req, 64'(q_mode), 64'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] a, r;
    int c, k;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 err", 64'(err), 0);
    for (int i = 0; i < NS; i++) expect_free("R1 slot", i);
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk: R2 R4 R5 R7 R10
    for (int v = 0; v < NV; v++) begin
      run_cmd(1'b0, VECS[v].a, VECS[v].l);
      chk("R5 count", 64'(count), 64'(VECS[v].n));
      chk("R7 err", 64'(err), 64'(VECS[v].e));
      chk("R5 busy low at done", 64'(busy), 0);
      a = 64'(VECS[v].a); r = 64'(VECS[v].l); k = 0;
      while (r != 0) begin
        c = best_code(a, r);
        if (c < 0) break;
        expect_slot("R2 R4 page", k, a, c);
        a += size_of(c); r -= size_of(c); k++;
      end
      chk("R2 model count", 64'(k), 64'(VECS[v].n));
      expect_free("R10 next slot free", k);
      @(negedge clk);
      chk("R5 done one cycle", 64'(done), 0);
      run_cmd(1'b1, '0, 41'h100_0000_0000);
      chk("R8 clear all count", 64'(count), 64'(VECS[v].n));
      expect_free("R8 cleared", 0);
    end

    // R9 start while busy ignored
    @(negedge clk);
    start = 1'b1; cmd = 1'b0; addr = 40'h1000; len = 41'h7000;
    @(negedge clk);
    start = 1'b0;
    chk("R5 busy during map", 64'(busy), 1);
    start = 1'b1; cmd = 1'b1; addr = '0; len = 41'h100_0000_0000;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R9 count", 64'(count), 4);
    chk("R9 err", 64'(err), 0);
    expect_slot("R9 slots kept", 3, 64'h4000, 1);
    run_cmd(1'b1, '0, 41'h100_0000_0000);

    // R11 fill all slots with single 4K pages
    for (int i = 0; i < NS; i++) begin
      run_cmd(1'b0, AW'((2 * i + 1) * 'h1000), 41'h1000);
      chk("R11 fill count", 64'(count), 1);
      chk("R11 fill err", 64'(err), 0);
    end
    expect_slot("R11 last slot", NS - 1, 64'h1F000, 0);
    run_cmd(1'b0, 40'h21000, 41'h1000);
    chk("R6 full count", 64'(count), 0);
    chk("R6 full err", 64'(err), 1);
    run_cmd(1'b0, 40'h800, 41'h1000);
    chk("R7 nospace over unaligned", 64'(err), 1);

    // R8 contained vs partial removal
    run_cmd(1'b1, 40'h3000, 41'h2000);
    chk("R8 contained count", 64'(count), 1);
    expect_free("R8 removed", 1);
    expect_slot("R8 neighbour kept", 2, 64'h5000, 0);
    run_cmd(1'b1, 40'h7800, 41'h1000);
    chk("R8 partial count", 64'(count), 0);
    expect_slot("R8 partial kept", 3, 64'h7000, 0);

    // R3 reuse lowest free slot
    run_cmd(1'b0, 40'h40000, 41'h1000);
    chk("R3 count", 64'(count), 1);
    expect_slot("R3 lowest free", 1, 64'h40000, 0);

    // R6 partial progress kept
    run_cmd(1'b1, 40'h1000, 41'h1000);
    run_cmd(1'b0, 40'h100000, 41'h2000);
    chk("R6 partial count", 64'(count), 1);
    chk("R6 partial err", 64'(err), 1);
    expect_slot("R6 kept entry", 0, 64'h100000, 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule